// File: doc/BRIEF.md
# Expiry-Guarded Watchdog Timer

This block is a watchdog peripheral that counts down from a programmable power-of-two period and must be restarted by software before it reaches zero. Software reaches it through a small word-addressed register port: a control word (enable and response mode), a period word holding two 4-bit period codes, a read-only view of the live count, and a write-only restart word that only accepts one magic value. A period code `n` selects a span of 2^(BASE_EXP+n) clock cycles. BASE_EXP is 16 in silicon and can be lowered for fast simulation.

Once software sets the enable it stays set until a hardware reset. Software cannot stop the count. When the count runs out, the block either drives its system-reset output at once, or first raises an interrupt and resets only if a second expiry follows with no restart in between. The system-reset output is a pulse of fixed length. The first countdown after enable uses the initial-period code. Every later reload uses the ordinary period code. Rewriting the period word while running also restarts the count.

Top module: `wdog_guard_top`

## Requirements
- R1: After hardware reset every readable register reads 0, and irq_o and sys_rst_o are low.
- R2: The register map is as follows, addressed by bus_addr. 0x0 is control: bit 0 is enable and bit 1 is response mode. 0x4 is period: bits [3:0] hold the reload code and bits [7:4] hold the initial code. 0x8 is the count, which is read-only, so writes to it have no effect. 0xC is restart, which is write-only and reads 0. While the timer is disabled the count holds 0 and a restart write has no effect.
- R3: Writing control with bit 0 set while disabled loads 2^(BASE_EXP+initial code)−1 into the count. After that the count drops by one on every clock.
- R4: While enabled, writing exactly 0x00000076 to restart reloads 2^(BASE_EXP+reload code)−1. Any other written value leaves the countdown untouched.
- R5: Enable is sticky. Writing 0 to control bit 0 leaves enable reading 1 and the count still running. Only hardware reset clears it.
- R6: While enabled, a period-word write stores the new codes and reloads 2^(BASE_EXP+new reload code)−1 at once.
- R7: The clock after the count reads 0 is an expiry. On an expiry the count reloads 2^(BASE_EXP+reload code)−1, so one period spans exactly 2^(BASE_EXP+code) cycles.
- R8: In response mode 0, an expiry drives sys_rst_o high for RST_PULSE cycles, starting the cycle after the expiry.
- R9: In response mode 1, the first expiry sets irq_o and does not drive sys_rst_o. A second expiry with no restart in between starts the sys_rst_o pulse.
- R10: A valid restart, or a period-word write while enabled, clears irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address while bus_sel is high and bus_wr is low |
| irq_o | output | 1 | Pre-reset warning interrupt (response mode 1) |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Restart writes are tried with the exact magic word, a word that differs only in its upper bits, and a near-miss low byte. This separates a full-word compare from a byte compare and from no compare at all. The first load after enable and the load after a restart use different initial and reload codes, so a design that mixes up the two codes shows a wrong count. Expiry is observed in the exact cycle in both response modes, with and without a restart between expiries. This checks the period length, the pulse start and width, and the two-strike interrupt sequence. Writes of 0 to enable and writes to the read-only count show that neither can stop or disturb the countdown.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_RANGE = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_KICK  = 4'hC;

  localparam int unsigned KICK_WORD = 32'h0000_0076;

  typedef enum logic {
    RESP_RESET     = 1'b0,
    RESP_IRQ_FIRST = 1'b1
  } resp_mode_e;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
  } load_req_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [DATA_W-1:0]     count_word,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  en,
  output resp_mode_e            mode,
  output logic [CODE_W-1:0]     reload_code,
  output load_req_t             load_req,
  output logic                  restart
);
  logic              en_q, en_d;
  resp_mode_e        mode_q, mode_d;
  logic [2*CODE_W-1:0] range_q, range_d;
  logic              ctrl_ce, range_ce;

  logic wr_ctrl, wr_range, wr_kick;
  logic kick_ok, range_reload, start;

  always_comb begin
    wr_ctrl  = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    wr_range = bus_sel && bus_wr && (bus_addr == OFS_RANGE);
    wr_kick  = bus_sel && bus_wr && (bus_addr == OFS_KICK);

    start        = wr_ctrl && bus_wdata[0] && !en_q;
    kick_ok      = wr_kick && en_q && (bus_wdata == DATA_W'(KICK_WORD));
    range_reload = wr_range && en_q;

    ctrl_ce  = wr_ctrl;
    range_ce = wr_range;
    en_d     = en_q || bus_wdata[0];
    mode_d   = resp_mode_e'(bus_wdata[1]);
    range_d  = bus_wdata[2*CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= RESP_RESET;
    end else if (ctrl_ce) begin
      en_q    <= en_d;
      mode_q  <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        range_q <= '0;
    else if (range_ce) range_q <= range_d;
  end

  always_comb begin
    load_req = '0;
    if (start) begin
      load_req.valid = 1'b1;
      load_req.code  = range_q[2*CODE_W-1:CODE_W];
    end else if (range_reload) begin
      load_req.valid = 1'b1;
      load_req.code  = bus_wdata[CODE_W-1:0];
    end else if (kick_ok) begin
      load_req.valid = 1'b1;
      load_req.code  = range_q[CODE_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        OFS_CTRL:  bus_rdata = DATA_W'({mode_q, en_q});
        OFS_RANGE: bus_rdata = DATA_W'(range_q);
        OFS_COUNT: bus_rdata = count_word;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign en          = en_q;
  assign mode        = mode_q;
  assign reload_code = range_q[CODE_W-1:0];
  assign restart     = kick_ok || range_reload;

  // R5: enable can only be cleared by hardware reset
  a_r5_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  // R4: a restart word other than the magic value causes no load
  a_r4_bad_kick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kick && bus_wdata != DATA_W'(KICK_WORD)) |-> !load_req.valid);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 16,
  localparam int unsigned CNT_W   = BASE_EXP + CODE_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  load_req_t         load_req,
  input  logic [CODE_W-1:0] reload_code,
  output logic [CNT_W-1:0]  cnt,
  output logic              expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  function automatic logic [CNT_W-1:0] span_max(input logic [CODE_W-1:0] code);
    span_max = {CNT_W{1'b1}} >> (CODE_W'(CODE_MAX) - code);
  endfunction

  always_comb begin
    expire = en && !load_req.valid && (cnt_q == '0);
    cnt_ce = load_req.valid || en;
    if (load_req.valid)  cnt_d = span_max(load_req.code);
    else if (expire)     cnt_d = span_max(reload_code);
    else                 cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3: a running, non-reloaded count drops by exactly one
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load_req.valid && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R2: disabled timer holds zero
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt_q == '0));
  // R7: an expiry reloads a non-zero period
  a_r7_reload_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q != '0));
endmodule

// File: rtl/wdog_response.sv
module wdog_response
  import wdog_pkg::*;
#(
  parameter int unsigned RST_PULSE = 8,
  localparam int unsigned PW       = $clog2(RST_PULSE + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  resp_mode_e mode,
  input  logic       restart,
  output logic       irq_o,
  output logic       sys_rst_o
);
  logic          irq_q, irq_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          fire, irq_ce, pulse_ce;

  always_comb begin
    fire     = expire && ((mode == RESP_RESET) || irq_q);
    irq_ce   = restart || (expire && mode == RESP_IRQ_FIRST);
    irq_d    = !restart;
    pulse_ce = fire || (pulse_q != '0);
    pulse_d  = fire ? PW'(RST_PULSE) : pulse_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_ce) irq_q <= irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse_q <= '0;
    else if (pulse_ce) pulse_q <= pulse_d;
  end

  assign irq_o     = irq_q;
  assign sys_rst_o = (pulse_q != '0);

  // R8: direct mode expiry starts the reset pulse next cycle
  a_r8_direct_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode == RESP_RESET) |=> sys_rst_o);
  // R9: first expiry in interrupt mode warns only
  a_r9_first_strike_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode == RESP_IRQ_FIRST && !irq_o) |=> irq_o);
  // R9: second strike resets
  a_r9_second_strike_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode == RESP_IRQ_FIRST && irq_o) |=> sys_rst_o);
  // R10: restart clears the warning
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !irq_o);
endmodule

// File: rtl/wdog_guard_top.sv
module wdog_guard_top
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP  = 16,
  parameter int unsigned RST_PULSE = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int unsigned CNT_W = BASE_EXP + CODE_MAX;

  logic [1:0]         rst_sync_q;
  logic               rst_core_n;
  logic               en, expire, restart;
  resp_mode_e         mode;
  logic [CODE_W-1:0]  reload_code;
  load_req_t          load_req;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  count_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign count_word = DATA_W'(cnt);

  wdog_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .count_word  (count_word),
    .bus_rdata   (bus_rdata),
    .en          (en),
    .mode        (mode),
    .reload_code (reload_code),
    .load_req    (load_req),
    .restart     (restart)
  );

  wdog_counter #(.BASE_EXP(BASE_EXP)) u_counter (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .en          (en),
    .load_req    (load_req),
    .reload_code (reload_code),
    .cnt         (cnt),
    .expire      (expire)
  );

  wdog_response #(.RST_PULSE(RST_PULSE)) u_resp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .expire    (expire),
    .mode      (mode),
    .restart   (restart),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o)
  );
endmodule

// File: tb/wdog_guard_top_tb_top.sv
module wdog_guard_top_tb_top;
  localparam int unsigned E  = 4;
  localparam int unsigned PL = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, sys_rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wdog_guard_top #(.BASE_EXP(E), .RST_PULSE(PL), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  function automatic logic [31:0] span(input int code);
    return (32'd1 << (E + code)) - 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic hw_reset();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    hw_reset();
    rd(4'h0, v); chk("R1 ctrl", v, 0);
    rd(4'h4, v); chk("R1 range", v, 0);
    rd(4'h8, v); chk("R1 count", v, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 sys_rst", {31'd0, sys_rst_o}, 0);
  endtask

  task automatic t_program_and_kick();
    logic [31:0] v;
    hw_reset();
    wr(4'h4, 32'h10);                 // initial code 1, reload code 0
    rd(4'h8, v); chk("R2 disabled count", v, 0);
    wr(4'hC, 32'h76);
    rd(4'h8, v); chk("R2 kick while disabled", v, 0);
    wr(4'h0, 32'h1);
    rd(4'h8, v); chk("R3 initial load", v, span(1));
    step(5);
    rd(4'h8, v); chk("R3 decrement", v, span(1) - 5);
    rd(4'h0, v); chk("R2 ctrl readback", v, 1);
    wr(4'hC, 32'h75);
    rd(4'h8, v); chk("R4 near-miss kick", v, span(1) - 6);
    wr(4'hC, 32'h176);
    rd(4'h8, v); chk("R4 upper bits kick", v, span(1) - 7);
    wr(4'h8, 32'h0);
    rd(4'h8, v); chk("R2 count read-only", v, span(1) - 8);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R5 enable sticky", v, 1);
    rd(4'h8, v); chk("R5 still counting", v, span(1) - 9);
    wr(4'hC, 32'h76);
    rd(4'h8, v); chk("R4 valid kick uses reload code", v, span(0));
    wr(4'h4, 32'h12);
    rd(4'h8, v); chk("R6 range write reloads", v, span(2));
    rd(4'h4, v); chk("R2 range readback", v, 32'h12);
    rd(4'hC, v); chk("R2 restart reads zero", v, 0);
  endtask

  task automatic t_direct_reset();
    logic [31:0] v;
    hw_reset();
    wr(4'h4, 32'h00);
    wr(4'h0, 32'h1);
    step(span(0));
    rd(4'h8, v); chk("R7 count at zero", v, 0);
    chk("R8 no reset before expiry", {31'd0, sys_rst_o}, 0);
    step(1);
    rd(4'h8, v); chk("R7 reload after expiry", v, span(0));
    chk("R8 reset pulse starts", {31'd0, sys_rst_o}, 1);
    chk("R8 no irq in mode 0", {31'd0, irq_o}, 0);
    step(PL - 1);
    chk("R8 pulse last cycle", {31'd0, sys_rst_o}, 1);
    step(1);
    chk("R8 pulse ends", {31'd0, sys_rst_o}, 0);
  endtask

  task automatic t_two_strike();
    logic [31:0] v;
    hw_reset();
    wr(4'h4, 32'h00);
    wr(4'h0, 32'h3);
    rd(4'h0, v); chk("R2 mode bit readback", v, 3);
    step(span(0) + 1);
    chk("R9 first expiry irq", {31'd0, irq_o}, 1);
    chk("R9 first expiry no reset", {31'd0, sys_rst_o}, 0);
    wr(4'hC, 32'h76);
    chk("R10 kick clears irq", {31'd0, irq_o}, 0);
    step(span(0) + 1);
    chk("R9 irq again after kick", {31'd0, irq_o}, 1);
    chk("R9 still no reset", {31'd0, sys_rst_o}, 0);
    wr(4'h4, 32'h00);
    chk("R10 range write clears irq", {31'd0, irq_o}, 0);
    step(span(0) + 1);
    chk("R9 third warning", {31'd0, irq_o}, 1);
    step(span(0) + 1);
    chk("R9 second strike reset", {31'd0, sys_rst_o}, 1);
  endtask

  initial begin
    t_reset_state();
    t_program_and_kick();
    t_direct_reset();
    t_two_strike();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule